// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data addresses for a load/store unit in a signal-processing datapath. It holds four register sets. Each set has a pointer, a window start, a window size and a step register. Every access names one set and one addressing mode. The block returns three things: the byte address for the access, the value the pointer would take after the access, and a flag that is raised when the address does not fit the access size.

Ring-buffer wrapping is done by the same adder path that computes the step, so it costs no extra cycle. The window may begin at any byte address. A bit-reversed step, where the carry runs from the top bit toward bit 0, supports transform reordering. An offset access reads from pointer plus offset and leaves the pointer as it was.

The access side has no back-pressure. The generator takes a request in every cycle that `acc_valid` is high, so there is no ready signal. The address, the next pointer and the alignment flag settle in the same cycle as the request. The pointer is written on the following clock edge. Registers are loaded through a plain load port.

Top module: `cbuf_agu`

## Requirements
- R1: After reset every pointer, window start, window size and step register of every set is zero, so an indirect access on any set returns address 0.
- R2: When `ld_en` is high, `ld_data` is written on the clock edge into the register of set `ld_set` chosen by `ld_fld` (0 pointer, 1 window start, 2 window size, 3 step). Other sets and other fields are not changed.
- R3: Mode 0 (indirect) outputs the pointer as the address and leaves the pointer unchanged.
- R4: Mode 1 (post-step) outputs the pointer as the address. On the edge where `acc_valid` is high, the pointer becomes pointer plus step (two's complement). The sum is linear when `acc_circ` is low or the window size is zero.
- R5: When wrapping is active (mode 1 or 3, `acc_circ` high, window size nonzero), a sum at or past start plus size has the size subtracted. With start 0, size 44 and step 16, the addresses from pointer 0 run 0, 16, 32, 4, 20, 36, 8, and so on.
- R6: With wrapping active and a negative step, a sum below the window start has the window size added. This holds for a window placed at any byte address, including addresses that are not powers of two.
- R7: Mode 2 (offset) outputs pointer plus `acc_offset` as the address and leaves the pointer unchanged.
- R8: Mode 3 (step only) updates the pointer exactly as mode 1 does. Its address output is the current pointer.
- R9: Mode 4 (bit-reversed) sets the pointer to pointer plus step, with the carry propagated from bit 31 toward bit 0. With step 16 from pointer 0, the pointers run 0, 16, 8, 24, 4, 20, 12, 28.
- R10: `misaligned` is high when the address is not a multiple of the access size. The size codes are 0 byte, 1 halfword (2), 2 word (4) and 3 doubleword (8).
- R11: If a pointer load and a pointer update hit the same set in the same cycle, the loaded value wins.
- R12: `next_index` shows, in the cycle of the request, the value the pointer will take. For modes 0 and 2 it equals the current pointer.
- R13: No pointer changes while `acc_valid` is low, whatever the other access inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Register load strobe |
| ld_set | input | 2 | Set written by a load |
| ld_fld | input | 2 | Field written: 0 pointer, 1 start, 2 size, 3 step |
| ld_data | input | 32 | Load value |
| acc_valid | input | 1 | Access request; accepted every cycle |
| acc_set | input | 2 | Set used by the access |
| acc_mode | input | 3 | 0 indirect, 1 post-step, 2 offset, 3 step only, 4 bit-reversed |
| acc_circ | input | 1 | Enables window wrapping for modes 1 and 3 |
| acc_offset | input | 32 | Offset for mode 2 |
| acc_size | input | 2 | Access size code |
| addr | output | 32 | Byte address of the access |
| next_index | output | 32 | Pointer value after this access |
| misaligned | output | 1 | Address not a multiple of the access size |

## Verification
The window-containment property assumes two things about each wrapping request. The pointer must already lie inside its window, and the step must be no larger in magnitude than the window size. If either does not hold, one add or subtract of the size cannot bring the sum back inside. The stimulus meets both conditions: it loads each pointer at the window start and draws step values from the range minus size to plus size. The write-back and stability properties exclude cycles in which a pointer load to the same set competes with an update. The bench covers that collision separately.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  typedef enum logic [2:0] {
    AM_IND  = 3'd0,
    AM_POST = 3'd1,
    AM_PRE  = 3'd2,
    AM_STEP = 3'd3,
    AM_BREV = 3'd4
  } am_e;

  typedef enum logic [1:0] {
    FLD_IDX  = 2'd0,
    FLD_BASE = 2'd1,
    FLD_LEN  = 2'd2,
    FLD_MOD  = 2'd3
  } fld_e;

  function automatic logic is_update(input logic [2:0] m);
    return (m == AM_POST) || (m == AM_STEP) || (m == AM_BREV);
  endfunction
endpackage

// File: rtl/cbuf_regfile.sv
module cbuf_regfile #(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [SW-1:0]             ld_set,
  input  logic [1:0]                ld_fld,
  input  logic [AW-1:0]             ld_data,
  input  logic                      wb_en,
  input  logic [SW-1:0]             wb_set,
  input  logic [AW-1:0]             wb_data,
  output logic [NSETS-1:0][AW-1:0]  idx_q,
  output logic [NSETS-1:0][AW-1:0]  base_q,
  output logic [NSETS-1:0][AW-1:0]  len_q,
  output logic [NSETS-1:0][AW-1:0]  mod_q
);
  import cbuf_pkg::*;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic hit_ld, hit_wb;
    assign hit_ld = ld_en && (ld_set == SW'(g));
    assign hit_wb = wb_en && (wb_set == SW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[g]  <= '0;
        base_q[g] <= '0;
        len_q[g]  <= '0;
        mod_q[g]  <= '0;
      end else begin
        // a load to the pointer takes priority over a write-back
        if (hit_ld && ld_fld == FLD_IDX) idx_q[g] <= ld_data;
        else if (hit_wb)                 idx_q[g] <= wb_data;
        if (hit_ld && ld_fld == FLD_BASE) base_q[g] <= ld_data;
        if (hit_ld && ld_fld == FLD_LEN)  len_q[g]  <= ld_data;
        if (hit_ld && ld_fld == FLD_MOD)  mod_q[g]  <= ld_data;
      end
    end
  end
endmodule

// File: rtl/cbuf_next_index.sv
module cbuf_next_index #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] stp,
  input  logic [2:0]    mode,
  input  logic          circ,
  output logic [AW-1:0] nxt
);
  import cbuf_pkg::*;
  localparam int DW = AW + 2;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [AW-1:0] lin, wrapped, brev;
  logic [DW-1:0] rel;
  logic          below, beyond, wrap_on;

  always_comb begin
    lin = idx + stp;
    // position of the sum relative to the window start, signed
    rel = {2'b00, idx} + {{2{stp[AW-1]}}, stp} - {2'b00, base};
    below  = rel[DW-1];
    beyond = !below && (rel[DW-2:0] >= {1'b0, len});
    wrap_on = circ && (len != '0);
    if (wrap_on && below)       wrapped = lin + len;
    else if (wrap_on && beyond) wrapped = lin - len;
    else                        wrapped = lin;
    brev = flip(flip(idx) + flip(stp));
    case (mode)
      AM_POST, AM_STEP: nxt = wrapped;
      AM_BREV:          nxt = brev;
      default:          nxt = idx;
    endcase
  end
endmodule

// File: rtl/cbuf_align_chk.sv
module cbuf_align_chk (
  input  logic [2:0] addr_lo,
  input  logic [1:0] size,
  output logic       mis
);
  always_comb begin
    case (size)
      2'd0:    mis = 1'b0;
      2'd1:    mis = addr_lo[0];
      2'd2:    mis = |addr_lo[1:0];
      default: mis = |addr_lo[2:0];
    endcase
  end
endmodule

// File: rtl/cbuf_agu.sv
module cbuf_agu #(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_set,
  input  logic [1:0]    ld_fld,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_valid,
  input  logic [SW-1:0] acc_set,
  input  logic [2:0]    acc_mode,
  input  logic          acc_circ,
  input  logic [AW-1:0] acc_offset,
  input  logic [1:0]    acc_size,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] next_index,
  output logic          misaligned
);
  import cbuf_pkg::*;

  logic [NSETS-1:0][AW-1:0] idx_q, base_q, len_q, mod_q;
  logic [AW-1:0] cur_idx, cur_base, cur_len, cur_mod;
  logic          wb_en;

  assign cur_idx  = idx_q[acc_set];
  assign cur_base = base_q[acc_set];
  assign cur_len  = len_q[acc_set];
  assign cur_mod  = mod_q[acc_set];
  assign wb_en    = acc_valid && is_update(acc_mode);
  assign addr     = (acc_mode == AM_PRE) ? cur_idx + acc_offset : cur_idx;

  cbuf_regfile #(.AW(AW), .NSETS(NSETS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_set(ld_set), .ld_fld(ld_fld), .ld_data(ld_data),
    .wb_en(wb_en), .wb_set(acc_set), .wb_data(next_index),
    .idx_q(idx_q), .base_q(base_q), .len_q(len_q), .mod_q(mod_q)
  );

  cbuf_next_index #(.AW(AW)) u_next (
    .idx(cur_idx), .base(cur_base), .len(cur_len), .stp(cur_mod),
    .mode(acc_mode), .circ(acc_circ), .nxt(next_index)
  );

  cbuf_align_chk u_align (
    .addr_lo(addr[2:0]), .size(acc_size), .mis(misaligned)
  );
endmodule

// File: rtl/cbuf_agu_chk.sv
module cbuf_agu_chk #(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ld_en,
  input logic [SW-1:0]            ld_set,
  input logic [1:0]               ld_fld,
  input logic [AW-1:0]            ld_data,
  input logic                     acc_valid,
  input logic [SW-1:0]            acc_set,
  input logic [2:0]               acc_mode,
  input logic                     acc_circ,
  input logic [1:0]               acc_size,
  input logic [AW-1:0]            addr,
  input logic [AW-1:0]            next_index,
  input logic                     misaligned,
  input logic [NSETS-1:0][AW-1:0] idx_q,
  input logic [NSETS-1:0][AW-1:0] base_q,
  input logic [NSETS-1:0][AW-1:0] len_q,
  input logic [NSETS-1:0][AW-1:0] mod_q
);
  import cbuf_pkg::*;

  logic [SW-1:0] p_set, p_ldset;
  logic [AW-1:0] p_nxt, p_lddata;
  always_ff @(posedge clk) begin
    p_set <= acc_set;  p_nxt <= next_index;
    p_ldset <= ld_set; p_lddata <= ld_data;
  end

  logic [AW-1:0] c_idx, c_base, c_len, c_mod, c_mag;
  logic upd, clash, fits;
  assign c_idx  = idx_q[acc_set];
  assign c_base = base_q[acc_set];
  assign c_len  = len_q[acc_set];
  assign c_mod  = mod_q[acc_set];
  assign c_mag  = c_mod[AW-1] ? -c_mod : c_mod;
  assign upd    = acc_valid && is_update(acc_mode);
  assign clash  = ld_en && ld_fld == FLD_IDX && ld_set == acc_set;
  assign fits   = (c_idx - c_base) < c_len && c_mag <= c_len;

  AST_PLAIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mode != AM_PRE |-> addr == c_idx); // R3
  AST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || !is_update(acc_mode)) && !ld_en |=> $stable(idx_q)); // R13
  AST_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !clash |=> idx_q[p_set] == p_nxt); // R12
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && ld_fld == FLD_IDX |=> idx_q[p_ldset] == p_lddata); // R11
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_circ && (acc_mode == AM_POST || acc_mode == AM_STEP) && c_len != '0 && fits
    |-> (next_index - c_base) < c_len); // R5
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_size == 2'd2 && $countones(addr[1:0]) == 0 |-> !misaligned); // R10
endmodule

bind cbuf_agu cbuf_agu_chk #(.AW(AW), .NSETS(NSETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_set(ld_set), .ld_fld(ld_fld),
  .ld_data(ld_data), .acc_valid(acc_valid), .acc_set(acc_set),
  .acc_mode(acc_mode), .acc_circ(acc_circ), .acc_size(acc_size), .addr(addr),
  .next_index(next_index), .misaligned(misaligned), .idx_q(idx_q),
  .base_q(base_q), .len_q(len_q), .mod_q(mod_q)
);

// File: tb/test_cbuf_agu.sv
`timescale 1ns/1ps
module test_cbuf_agu;
  logic clk = 0, rst_n = 0;
  logic ld_en = 0, acc_valid = 0, acc_circ = 0;
  logic [1:0] ld_set = 0, ld_fld = 0, acc_set = 0, acc_size = 0;
  logic [2:0] acc_mode = 0;
  logic [31:0] ld_data = 0, acc_offset = 0;
  logic [31:0] addr, next_index;
  logic misaligned;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] ri[4], rb[4], rl[4], rm[4];

  always #10 clk = ~clk;

  cbuf_agu i_cbuf_agu (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input int s, input logic [2:0] m, input logic c);
    longint rel;
    logic [31:0] sum, r;
    logic cy, bs;
    if (m == 3'd1 || m == 3'd3) begin
      sum = ri[s] + rm[s];
      if (c && rl[s] != 0) begin
        rel = longint'(ri[s]) - longint'(rb[s]) + longint'($signed(rm[s]));
        if (rel < 0) sum = sum + rl[s];
        else if (rel >= longint'(rl[s])) sum = sum - rl[s];
      end
      return sum;
    end else if (m == 3'd4) begin
      cy = 0;
      for (int b = 31; b >= 0; b--) begin
        bs = ri[s][b] ^ rm[s][b] ^ cy;
        cy = (ri[s][b] & rm[s][b]) | (cy & (ri[s][b] ^ rm[s][b]));
        r[b] = bs;
      end
      return r;
    end
    return ri[s];
  endfunction

  task automatic load(input int s, input int f, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 0; ld_en = 1; ld_set = 2'(s); ld_fld = 2'(f); ld_data = d;
    @(posedge clk);
    case (f) 0: ri[s] = d; 1: rb[s] = d; 2: rl[s] = d; default: rm[s] = d; endcase
    #1 ld_en = 0;
  endtask

  task automatic access(input string req, input int s, input logic [2:0] m,
                        input logic c, input logic [31:0] off, input logic [1:0] sz,
                        input logic v);
    logic [31:0] ea, en;
    @(negedge clk);
    ld_en = 0; acc_valid = v; acc_set = 2'(s); acc_mode = m; acc_circ = c;
    acc_offset = off; acc_size = sz;
    ea = (m == 3'd2) ? ri[s] + off : ri[s];
    en = model_next(s, m, c);
    #2;
    chk({req, " addr"}, addr, ea);
    chk({req, " next"}, next_index, en);
    chk({req, " mis"}, 32'(misaligned), 32'((ea % (32'd1 << sz)) != 0));
    @(posedge clk);
    if (v) ri[s] = en;
    #1 acc_valid = 0;
  endtask

  task automatic setup(input int s, input logic [31:0] i, b, l, m);
    load(s, 0, i); load(s, 1, b); load(s, 2, l); load(s, 3, m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seq[7] = '{0, 16, 32, 4, 20, 36, 8};
    logic [31:0] bseq[8] = '{0, 16, 8, 24, 4, 20, 12, 28};
    for (int s = 0; s < 4; s++) begin ri[s] = 0; rb[s] = 0; rl[s] = 0; rm[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int s = 0; s < 4; s++) access("R1 reset", s, 3'd0, 0, 0, 2, 1);

    // R2: loads land only in the named set
    load(2, 0, 32'h0000_1234);
    for (int s = 0; s < 4; s++) access("R2 load", s, 3'd0, 0, 0, 0, 1);
    // R3: indirect leaves pointer
    access("R3 indirect", 2, 3'd0, 0, 0, 0, 1);
    access("R3 again", 2, 3'd0, 0, 0, 0, 1);

    // R5: worked ring sequence
    setup(0, 0, 0, 44, 16);
    for (int k = 0; k < 7; k++) begin
      chk("R5 ring seq", ri[0], seq[k]);
      access("R5 ring", 0, 3'd1, 1, 0, 2, 1);
    end
    // R4: linear when wrap off, and when size zero
    setup(1, 32'h100, 32'h100, 0, 32'hFFFF_FFF8);
    for (int k = 0; k < 4; k++) access("R4 size0", 1, 3'd1, 1, 0, 2, 1);
    setup(1, 32'h100, 32'h100, 8, 12);
    for (int k = 0; k < 4; k++) access("R4 circ off", 1, 3'd1, 0, 0, 2, 1);

    // R5/R6/R8: sweep of sizes and steps, odd placement
    foreach (seq[q]) begin end
    for (int li = 0; li < 3; li++) begin
      logic [31:0] L;
      L = (li == 0) ? 12 : (li == 1) ? 20 : 44;
      for (int mv = -int'(L); mv <= int'(L); mv += 4) begin
        setup(3, 32'd1000 + 32'd4, 32'd1000 + 32'd4, L, 32'(mv));
        for (int k = 0; k < 6; k++)
          access(mv < 0 ? "R6 neg wrap" : "R5 pos wrap", 3, (k[0] ? 3'd3 : 3'd1), 1, 0, 2, 1);
        access("R8 step only", 3, 3'd3, 1, 0, 0, 1);
      end
    end

    // R7: offset access keeps pointer
    setup(2, 32'h2000, 0, 0, 4);
    access("R7 offset", 2, 3'd2, 0, 32'h40, 2, 1);
    access("R7 kept", 2, 3'd0, 0, 0, 2, 1);

    // R9: bit-reversed walk
    setup(1, 0, 0, 0, 16);
    for (int k = 0; k < 8; k++) begin
      chk("R9 brev seq", ri[1], bseq[k]);
      access("R9 brev", 1, 3'd4, 0, 0, 2, 1);
    end
    setup(1, 0, 0, 0, 32'h80);
    for (int k = 0; k < 16; k++) access("R9 brev model", 1, 3'd4, 0, 0, 2, 1);

    // R10: every low address with every size
    setup(0, 32'h300, 0, 0, 0);
    for (int a = 0; a < 8; a++)
      for (int z = 0; z < 4; z++) access("R10 align", 0, 3'd2, 0, 32'(a), 2'(z), 1);

    // R11: load and update on same set in same cycle
    setup(2, 32'h40, 0, 0, 4);
    @(negedge clk);
    ld_en = 1; ld_set = 2; ld_fld = 0; ld_data = 32'h777;
    acc_valid = 1; acc_set = 2; acc_mode = 3'd1; acc_circ = 0;
    @(posedge clk);
    ri[2] = 32'h777;
    #1 begin ld_en = 0; acc_valid = 0; end
    access("R11 load wins", 2, 3'd0, 0, 0, 0, 1);

    // R12: next_index on non-updating modes tracked inside access()
    access("R12 preview", 2, 3'd1, 0, 0, 0, 1);
    // R13: requests with valid low change nothing
    access("R13 idle", 2, 3'd1, 0, 0, 0, 0);
    access("R13 idle brev", 2, 3'd4, 0, 0, 0, 0);
    access("R13 check", 2, 3'd0, 0, 0, 0, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule